// File: doc/BRIEF.md
# Swizzled Masked Vector Register ALU

This block pairs a 32-entry file of 96-bit vector registers with a single-cycle adder. Each register holds four 24-bit lanes, named a, b, c and d. One instruction reads two source registers. Each source passes through its own lane swizzle, which lets any source lane feed any operand lane. The two swizzled operands are then either added lane by lane or, for a move, the first operand is passed through alone. The result is written only into the destination lanes that the write mask enables. Lanes left out of the mask keep their contents, and their computed results are thrown away.

Each lane word is treated as plain 24-bit two's complement. That covers both integer data and signed fixed-point data with 1 sign bit, 7 integer bits and 16 fraction bits, since the adder is the same for both. A per-lane signed-overflow flag is reported for the written lanes, in the cycle after the instruction. A host write port preloads whole registers, and a combinational debug port reads any register back.

There is no multi-cycle sequencing. An instruction presented with `ins_valid` commits on the next rising clock edge, and a one-cycle `done` pulse marks that commit.

Top module: `swz_vec_alu`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 registers to zero and drives `done` and `ovf_flags` to zero.
- R2: Lane a occupies bits 23:0, lane b bits 47:24, lane c bits 71:48 and lane d bits 95:72. A host write (`host_we`) replaces the whole 96-bit register at the next edge. `dbg_data` shows register `dbg_addr` combinationally.
- R3: Each swizzle is 8 bits. Bits [2i+1:2i] pick the source lane that feeds operand lane i, coded a=0, b=1, c=2, d=3. Repeats are allowed, and the two sources are swizzled independently.
- R4: With opcode 0 (add), result lane i equals swizzled operand-1 lane i plus swizzled operand-2 lane i, wrapped modulo 2^24.
- R5: Write mask bit i (bit 0 = lane a) enables the write of destination lane i. Destination lanes with a clear mask bit keep their previous value.
- R6: For an add, the overflow flag of lane i is set when both operand lanes have the same sign bit and the result sign bit differs from it.
- R7: `ovf_flags` is registered and appears in the cycle after the instruction. Its bit i is forced to zero when mask bit i is clear.
- R8: With opcode 1 (move), the masked destination lanes receive swizzled operand 1. Source 2 and swizzle 2 have no effect, and all overflow flags are zero.
- R9: A host write in a cycle where `ins_valid` is high is ignored, and the addressed register keeps its value.
- R10: Sources are read before the write. An instruction whose destination is also a source uses the old values, and the new value is visible on `dbg_data` after the committing edge.
- R11: `done` is high for exactly the cycle after each cycle with `ins_valid` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_op | input | 1 | 0 = add, 1 = move |
| ins_dst | input | 5 | Destination register index |
| ins_mask | input | 4 | Destination lane write mask, bit 0 = lane a |
| ins_src1 | input | 5 | First source register index |
| ins_swz1 | input | 8 | Swizzle of first source |
| ins_src2 | input | 5 | Second source register index |
| ins_swz2 | input | 8 | Swizzle of second source |
| host_we | input | 1 | Host full-register write enable |
| host_addr | input | 5 | Host write register index |
| host_data | input | 96 | Host write data |
| dbg_addr | input | 5 | Debug read register index |
| dbg_data | output | 96 | Debug read data, combinational |
| done | output | 1 | Instruction committed on the last edge |
| ovf_flags | output | 4 | Per-lane signed overflow of the committed instruction |

## Verification
The bench builds the block with its defaults: 24-bit lanes, four lanes and 32 registers. At that size it can preload and sweep every register address, and random instructions reach every 2-bit swizzle code in every lane position of both sources. The overflow boundary at bit 23 is hit directly, with 0x7FFFFF+1 and 0x800000+0x800000. Directed cases cover a destination that aliases a source, a move with a source 2 that would cause overflow, and a host write that collides with an instruction.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    typedef enum logic [0:0] {
        OP_ADD = 1'b0,
        OP_MOV = 1'b1
    } vrf_op_e;

endpackage

// File: rtl/vrf_swizzle.sv
module vrf_swizzle #(
    parameter int LANE_W = 24,
    parameter int LANES  = 4
) (
    input  logic [LANES*LANE_W-1:0]         src,
    input  logic [LANES*$clog2(LANES)-1:0]  swz,
    output logic [LANES*LANE_W-1:0]         opnd
);
    localparam int SEL_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEL_W-1:0] sel;
        assign sel = swz[i*SEL_W +: SEL_W];
        always_comb begin
            opnd[i*LANE_W +: LANE_W] = '0;
            for (int k = 0; k < LANES; k++) begin
                if (sel == SEL_W'(k)) begin
                    opnd[i*LANE_W +: LANE_W] = src[k*LANE_W +: LANE_W];
                end
            end
        end
    end

endmodule

// File: rtl/vrf_lane_alu.sv
module vrf_lane_alu
    import vrf_pkg::*;
#(
    parameter int LANE_W = 24
) (
    input  vrf_op_e            op,
    input  logic [LANE_W-1:0]  opa,
    input  logic [LANE_W-1:0]  opb,
    output logic [LANE_W-1:0]  res,
    output logic               ovf
);
    localparam int MSB = LANE_W - 1;

    logic [LANE_W-1:0] sum;
    assign sum = opa + opb;

    always_comb begin
        unique case (op)
            OP_ADD: begin
                res = sum;
                ovf = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
            end
            OP_MOV: begin
                res = opa;
                ovf = 1'b0;
            end
            default: begin
                res = opa;
                ovf = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vrf_regfile.sv
module vrf_regfile #(
    parameter int LANE_W = 24,
    parameter int LANES  = 4,
    parameter int DEPTH  = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(DEPTH)-1:0]    wr_addr,
    input  logic [LANES-1:0]            wr_mask,
    input  logic [LANES*LANE_W-1:0]     wr_data,
    input  logic                        host_we,
    input  logic [$clog2(DEPTH)-1:0]    host_addr,
    input  logic [LANES*LANE_W-1:0]     host_data,
    input  logic [$clog2(DEPTH)-1:0]    rd1_addr,
    output logic [LANES*LANE_W-1:0]     rd1_data,
    input  logic [$clog2(DEPTH)-1:0]    rd2_addr,
    output logic [LANES*LANE_W-1:0]     rd2_data,
    input  logic [$clog2(DEPTH)-1:0]    dbg_addr,
    output logic [LANES*LANE_W-1:0]     dbg_data
);
    localparam int REG_W = LANES * LANE_W;

    logic [REG_W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < DEPTH; r++) begin
                regs[r] <= '0;
            end
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_mask[l]) begin
                    regs[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
                end
            end
        end else if (host_we) begin
            regs[host_addr] <= host_data;
        end
    end

    assign rd1_data = regs[rd1_addr];
    assign rd2_data = regs[rd2_addr];
    assign dbg_data = regs[dbg_addr];

    // Checking support: old contents and the lanes a write must leave alone.
    logic [REG_W-1:0] dst_old;
    logic [REG_W-1:0] host_old;
    logic [REG_W-1:0] keep_bits;
    assign dst_old  = regs[wr_addr];
    assign host_old = regs[host_addr];
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            keep_bits[l*LANE_W +: LANE_W] = {LANE_W{~wr_mask[l]}};
        end
    end

    // R5: lanes outside the mask survive an instruction write.
    a_r5_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((regs[$past(wr_addr)] & $past(keep_bits)) ==
                   ($past(dst_old) & $past(keep_bits))));

    // R9: a host write colliding with an instruction is dropped.
    a_r9_host_blocked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && host_we && (host_addr != wr_addr)) |=>
            (regs[$past(host_addr)] == $past(host_old)));

endmodule

// File: rtl/swz_vec_alu.sv
module swz_vec_alu
    import vrf_pkg::*;
#(
    parameter int LANE_W = 24,
    parameter int LANES  = 4,
    parameter int DEPTH  = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               ins_valid,
    input  logic                               ins_op,
    input  logic [$clog2(DEPTH)-1:0]           ins_dst,
    input  logic [LANES-1:0]                   ins_mask,
    input  logic [$clog2(DEPTH)-1:0]           ins_src1,
    input  logic [LANES*$clog2(LANES)-1:0]     ins_swz1,
    input  logic [$clog2(DEPTH)-1:0]           ins_src2,
    input  logic [LANES*$clog2(LANES)-1:0]     ins_swz2,
    input  logic                               host_we,
    input  logic [$clog2(DEPTH)-1:0]           host_addr,
    input  logic [LANES*LANE_W-1:0]            host_data,
    input  logic [$clog2(DEPTH)-1:0]           dbg_addr,
    output logic [LANES*LANE_W-1:0]            dbg_data,
    output logic                               done,
    output logic [LANES-1:0]                   ovf_flags
);
    localparam int REG_W = LANES * LANE_W;

    vrf_op_e          op_sel;
    logic [REG_W-1:0] src1_raw;
    logic [REG_W-1:0] src2_raw;
    logic [REG_W-1:0] opnd1;
    logic [REG_W-1:0] opnd2;
    logic [REG_W-1:0] result;
    logic [LANES-1:0] lane_ovf;

    assign op_sel = vrf_op_e'(ins_op);

    vrf_regfile #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ins_valid),
        .wr_addr   (ins_dst),
        .wr_mask   (ins_mask),
        .wr_data   (result),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_data (host_data),
        .rd1_addr  (ins_src1),
        .rd1_data  (src1_raw),
        .rd2_addr  (ins_src2),
        .rd2_data  (src2_raw),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data)
    );

    vrf_swizzle #(.LANE_W(LANE_W), .LANES(LANES)) u_swz1 (
        .src  (src1_raw),
        .swz  (ins_swz1),
        .opnd (opnd1)
    );

    vrf_swizzle #(.LANE_W(LANE_W), .LANES(LANES)) u_swz2 (
        .src  (src2_raw),
        .swz  (ins_swz2),
        .opnd (opnd2)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_alu
        vrf_lane_alu #(.LANE_W(LANE_W)) u_alu (
            .op  (op_sel),
            .opa (opnd1[i*LANE_W +: LANE_W]),
            .opb (opnd2[i*LANE_W +: LANE_W]),
            .res (result[i*LANE_W +: LANE_W]),
            .ovf (lane_ovf[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            ovf_flags <= '0;
        end else begin
            done      <= ins_valid;
            ovf_flags <= ins_valid ? (lane_ovf & ins_mask) : '0;
        end
    end

    // R7: no flag appears for a lane the mask left out.
    a_r7_flags_masked: assert property (@(posedge clk) disable iff (rst)
        ins_valid |=> ((ovf_flags & ~$past(ins_mask)) == '0));

    // R8: a move never reports overflow.
    a_r8_mov_no_flag: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_op == OP_MOV) |=> (ovf_flags == '0));

    // R11: done follows each instruction by one cycle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        ins_valid |=> done);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        !ins_valid |=> (!done && ovf_flags == '0));

endmodule

// File: tb/tb_swz_vec_alu.sv
`timescale 1ns/100ps
module tb_swz_vec_alu;

    logic        clk = 1'b0;
    logic        rst;
    logic        ins_valid;
    logic        ins_op;
    logic [4:0]  ins_dst;
    logic [3:0]  ins_mask;
    logic [4:0]  ins_src1;
    logic [7:0]  ins_swz1;
    logic [4:0]  ins_src2;
    logic [7:0]  ins_swz2;
    logic        host_we;
    logic [4:0]  host_addr;
    logic [95:0] host_data;
    logic [4:0]  dbg_addr;
    logic [95:0] dbg_data;
    logic        done;
    logic [3:0]  ovf_flags;

    int n_checks = 0;
    int n_fail   = 0;

    logic [95:0] model [32];

    always #2.5 clk = ~clk;

    swz_vec_alu #(.LANE_W(24), .LANES(4), .DEPTH(32)) dut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_dst(ins_dst), .ins_mask(ins_mask), .ins_src1(ins_src1),
        .ins_swz1(ins_swz1), .ins_src2(ins_src2), .ins_swz2(ins_swz2),
        .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data), .done(done),
        .ovf_flags(ovf_flags)
    );

    task automatic chk(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] swz(input int e0, e1, e2, e3);
        return 8'(e0 | (e1 << 2) | (e2 << 4) | (e3 << 6));
    endfunction

    function automatic logic [95:0] mk(input logic [23:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    task automatic check_all(input string req);
        for (int r = 0; r < 32; r++) begin
            dbg_addr = 5'(r);
            #0.05;
            chk(dbg_data === model[r], req, dbg_data, model[r]);
        end
    endtask

    task automatic host_wr(input int a, input logic [95:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(a); host_data = d;
        @(posedge clk);
        #0.5;
        host_we = 1'b0;
        model[a] = d;
        dbg_addr = 5'(a);
        #0.5;
        chk(dbg_data === d, "R2 host write", dbg_data, d);
        chk(done === 1'b0 && ovf_flags === 4'b0, "R11 idle done low",
            {91'b0, done, ovf_flags}, 96'b0);
    endtask

    task automatic run_ins(input bit op, input int dst, input int mask,
                           input int s1, input int w1, input int s2, input int w2,
                           input bit hw, input int ha, input logic [95:0] hd,
                           input string req);
        logic [95:0] nv;
        logic [3:0]  eflags;
        logic [23:0] x, y, s;
        @(negedge clk);
        ins_valid = 1'b1; ins_op = op; ins_dst = 5'(dst); ins_mask = 4'(mask);
        ins_src1 = 5'(s1); ins_swz1 = 8'(w1); ins_src2 = 5'(s2); ins_swz2 = 8'(w2);
        host_we = hw; host_addr = 5'(ha); host_data = hd;
        nv = model[dst];
        eflags = 4'b0;
        for (int i = 0; i < 4; i++) begin
            x = model[s1][((w1 >> (2*i)) & 3)*24 +: 24];
            y = model[s2][((w2 >> (2*i)) & 3)*24 +: 24];
            if (op) begin
                s = x;
            end else begin
                s = x + y;
                if (((mask >> i) & 1) == 1 && x[23] == y[23] && s[23] != x[23])
                    eflags[i] = 1'b1;
            end
            if (((mask >> i) & 1) == 1) nv[i*24 +: 24] = s;
        end
        @(posedge clk);
        #0.5;
        ins_valid = 1'b0; host_we = 1'b0;
        model[dst] = nv;
        dbg_addr = 5'(dst);
        #0.5;
        chk(done === 1'b1, {req, " / R11 done"}, {95'b0, done}, 96'b1);
        chk(ovf_flags === eflags, {req, " / R7 flags"}, {92'b0, ovf_flags}, {92'b0, eflags});
        chk(dbg_data === model[dst], req, dbg_data, model[dst]);
        if (hw) begin
            dbg_addr = 5'(ha);
            #0.2;
            chk(dbg_data === model[ha], "R9 host write ignored", dbg_data, model[ha]);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; ins_valid = 1'b0; ins_op = 1'b0; ins_dst = '0; ins_mask = '0;
        ins_src1 = '0; ins_swz1 = '0; ins_src2 = '0; ins_swz2 = '0;
        host_we = 1'b0; host_addr = '0; host_data = '0; dbg_addr = '0;
        for (int r = 0; r < 32; r++) model[r] = '0;
        repeat (3) @(posedge clk);
        #0.5;
        rst = 1'b0;
        #0.5;
        // R1: reset state
        check_all("R1 reset clears registers");
        chk(done === 1'b0 && ovf_flags === 4'b0, "R1 reset outputs",
            {91'b0, done, ovf_flags}, 96'b0);

        // R2: preload all registers, then check lane layout
        for (int r = 0; r < 32; r++) host_wr(r, {$urandom, $urandom, $urandom});
        host_wr(5, mk(24'hAAAAAA, 24'hBBBBBB, 24'hCCCCCC, 24'hDDDDDD));
        dbg_addr = 5'd5; #0.1;
        chk(dbg_data[23:0] === 24'hAAAAAA, "R2 lane a bits", {72'b0, dbg_data[23:0]}, {72'b0, 24'hAAAAAA});
        chk(dbg_data[95:72] === 24'hDDDDDD, "R2 lane d bits", {72'b0, dbg_data[95:72]}, {72'b0, 24'hDDDDDD});
        check_all("R2 preload sweep");

        host_wr(1, mk(24'h10, 24'h20, 24'h30, 24'h40));
        host_wr(2, mk(24'h100, 24'h200, 24'h300, 24'h400));
        host_wr(4, mk(24'h555555, 24'h555555, 24'h555555, 24'h555555));
        // R4: identity swizzles, full mask
        run_ins(1'b0, 3, 4'hF, 1, swz(0,1,2,3), 2, swz(0,1,2,3), 1'b0, 0, '0, "R4 add identity");
        chk(model[3] === mk(24'h110, 24'h220, 24'h330, 24'h440), "R4 add value",
            model[3], mk(24'h110, 24'h220, 24'h330, 24'h440));
        // R3 + R5: repeated swizzles, mask ab only
        run_ins(1'b0, 4, 4'b0011, 1, swz(0,1,0,1), 2, swz(1,1,0,0), 1'b0, 0, '0, "R3 R5 swizzle abab+bbaa mask ab");
        // R3: reversed swizzle
        run_ins(1'b0, 12, 4'hF, 2, swz(3,2,1,0), 1, swz(2,2,2,2), 1'b0, 0, '0, "R3 reversed swizzle");

        // R6: overflow boundaries
        host_wr(6, mk(24'h7FFFFF, 24'h800000, 24'h000005, 24'hFFFFFF));
        host_wr(7, mk(24'h000001, 24'h800000, 24'h000003, 24'hFFFFFF));
        run_ins(1'b0, 8, 4'hF, 6, swz(0,1,2,3), 7, swz(0,1,2,3), 1'b0, 0, '0, "R6 overflow lanes");
        chk(model[8] === mk(24'h800000, 24'h000000, 24'h000008, 24'hFFFFFE), "R4 wrap value",
            model[8], mk(24'h800000, 24'h000000, 24'h000008, 24'hFFFFFE));
        // R7: flag of an unwritten lane is suppressed
        run_ins(1'b0, 13, 4'b0010, 6, swz(0,1,2,3), 7, swz(0,1,2,3), 1'b0, 0, '0, "R7 masked flags");

        // R8: move ignores source 2 (which would overflow)
        run_ins(1'b1, 9, 4'b1010, 1, swz(3,2,1,0), 6, swz(0,0,0,0), 1'b0, 0, '0, "R8 move");
        run_ins(1'b1, 14, 4'hF, 6, swz(0,0,0,0), 6, swz(1,1,1,1), 1'b0, 0, '0, "R8 move no flags");

        // R9: host write colliding with instruction
        run_ins(1'b0, 10, 4'hF, 1, swz(0,1,2,3), 2, swz(0,1,2,3), 1'b1, 11,
                96'hDEAD_BEEF_0123_4567_89AB_CDEF, "R9 collide");

        // R10: destination aliases both sources
        run_ins(1'b0, 1, 4'hF, 1, swz(1,2,3,0), 1, swz(0,1,2,3), 1'b0, 0, '0, "R10 read before write");

        // Random mix compared against the model
        for (int k = 0; k < 400; k++) begin
            run_ins(1'($urandom), int'($urandom % 32), int'($urandom % 16),
                    int'($urandom % 32), int'($urandom % 256),
                    int'($urandom % 32), int'($urandom % 256),
                    1'($urandom), int'($urandom % 32), {$urandom, $urandom, $urandom},
                    "R3 R4 R5 R6 R8 random");
        end
        host_wr(20, {$urandom, $urandom, $urandom});
        check_all("R5 R10 final sweep");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule